// File: doc/BRIEF.md
# Fly-By DMA Channel Sequencer

This block runs one DMA channel in single-address (fly-by) mode. Memory and an external I/O device exchange data over a shared data bus in the same bus cycle, so the channel holds no data of its own. When a request is accepted, the channel drives an active-low acknowledge pulse and, in the same cycle, puts its memory address on the bus and raises a memory read or write strobe. The device uses the acknowledge pulse as its own strobe. It drives the bus for a memory write, or captures the bus during a memory read. The channel never drives the data bus.

A direction input selects which way the data moves. The transfer data size and the device width set how many bus operations make up one transfer. After each bus operation the address moves forward by the device width. A transfer counter counts down once per complete transfer. When it reaches zero, the channel pulses an active-low end-of-transfer output and sets a sticky interrupt flag in the same cycle. The address and counter are loaded through a load strobe while the channel is idle.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, dack_n and end_n are 1, and irq, mem_rd and mem_wr are 0.
- R2: A request is sampled on a rising edge while the channel is idle and enabled with a nonzero counter. In the next cycle, dack_n is 0, one memory strobe is 1, and mem_addr equals the address register.
- R3: cfg_dir = 0 (memory to device) makes each bus operation a memory read (mem_rd = 1). cfg_dir = 1 (device to memory) makes it a memory write (mem_wr = 1). mem_rd and mem_wr are never 1 together.
- R4: The number of bus operations per transfer depends on the data size and the device width. The size codes are 2'b00 = 8-bit, 2'b01 = 16-bit and 2'b10 = 32-bit; 2'b11 is treated like 8-bit. The width codes are 0 = 8-bit and 1 = 16-bit.
  - 32-bit on an 8-bit device takes 4 operations.
  - 32-bit on a 16-bit device takes 2.
  - 16-bit on an 8-bit device takes 2.
  - Every other combination takes 1.
- R5: After each bus operation the address grows by 1 for an 8-bit device and by 2 for a 16-bit device. The new address carries over into the next transfer.
- R6: dack_n is 0 for exactly one cycle per bus operation. It is 1 for at least one cycle between two operations, whether they belong to the same transfer or to different ones.
- R7: The counter drops by one per completed transfer. When the transfer that brings it to zero finishes its last operation, end_n is 0 for one cycle in the next cycle, and irq becomes 1 in that same cycle.
- R8: irq stays 1 until irq_clr is pulsed. It is 0 from the cycle after the pulse.
- R9: A request while ch_en is 0, or while the counter is zero, starts no bus operation (dack_n stays 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| cfg_dir | input | 1 | 1 = device to memory, 0 = memory to device |
| cfg_dsize | input | 2 | Transfer data size code |
| cfg_devw | input | 1 | Device width code |
| ld_valid | input | 1 | Load address and counter (taken while idle) |
| ld_addr | input | AW | Start address to load |
| ld_count | input | CW | Transfer count to load |
| irq_clr | input | 1 | Clears the interrupt flag |
| dreq | input | 1 | DMA request |
| dack_n | output | 1 | Active-low acknowledge, one pulse per bus operation |
| end_n | output | 1 | Active-low end-of-transfer pulse |
| irq | output | 1 | Sticky completion interrupt |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
On every cycle, the embedded properties check four things:
- the acknowledge pulse always comes with exactly one memory strobe and lasts a single cycle;
- end-of-transfer never shows without the interrupt, and the interrupt never drops without a clear;
- the address moves by the latched step on each operation, and the counter never decrements from zero;
- a disabled or exhausted channel never leaves idle.

Only the scenarios show the rest. These are the exact address sequence across transfers of mixed sizes, the number of operations for each size and width pair, and the placement of the end pulse on the transfer that empties the counter.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

   localparam int unsigned OPW = 3;

   localparam logic [1:0] SZ_B8  = 2'b00;
   localparam logic [1:0] SZ_B16 = 2'b01;
   localparam logic [1:0] SZ_B32 = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OP   = 2'd1,
      ST_GAP  = 2'd2
   } seq_st_e;

endpackage

// File: rtl/flyby_op_plan.sv
module flyby_op_plan
   import flyby_dma_pkg::*;
(
   input  logic [1:0]     dsize,
   input  logic           devw,
   output logic [OPW-1:0] nops,
   output logic [1:0]     step
);

   always_comb begin
      nops = OPW'(1);
      if (dsize == SZ_B32)
         nops = devw ? OPW'(2) : OPW'(4);
      else if (dsize == SZ_B16 && !devw)
         nops = OPW'(2);
   end

   assign step = devw ? 2'd2 : 2'd1;

endmodule

// File: rtl/flyby_addr_gen.sv
module flyby_addr_gen #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          adv,
   input  logic [1:0]    step,
   output logic [AW-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= load_val;
      else if (adv)
         addr <= addr + AW'(step);
   end

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (addr == $past(addr) + AW'($past(step))));

endmodule

// File: rtl/flyby_xfer_ctr.sv
module flyby_xfer_ctr #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec)
         cnt_q <= cnt_q - CW'(1);
   end

   assign zero = (cnt_q == '0);
   assign last = (cnt_q == CW'(1));

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero);

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
   import flyby_dma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ch_en,
   input  logic          cfg_dir,
   input  logic [1:0]    cfg_dsize,
   input  logic          cfg_devw,
   input  logic          ld_valid,
   input  logic [AW-1:0] ld_addr,
   input  logic [CW-1:0] ld_count,
   input  logic          irq_clr,
   input  logic          dreq,
   output logic          dack_n,
   output logic          end_n,
   output logic          irq,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr
);

   if (AW < 4) begin : g_bad_aw
      $error("flyby_dma_chan: AW must be at least 4");
   end
   if (CW < 2) begin : g_bad_cw
      $error("flyby_dma_chan: CW must be at least 2");
   end

   seq_st_e        st_q;
   logic [OPW-1:0] left_q;
   logic           dir_q;
   logic [1:0]     step_q;
   logic           end_q;
   logic           irq_q;
   logic [OPW-1:0] plan_nops;
   logic [1:0]     plan_step;
   logic           cnt_zero;
   logic           cnt_last;
   logic           idle;
   logic           load_ok;
   logic           accept;
   logic           op_now;
   logic           op_last;

   assign idle    = (st_q == ST_IDLE);
   assign load_ok = idle && ld_valid;
   assign accept  = idle && dreq && ch_en && !cnt_zero && !ld_valid;
   assign op_now  = (st_q == ST_OP);
   assign op_last = op_now && (left_q == '0);

   flyby_op_plan u_plan (
      .dsize (cfg_dsize),
      .devw  (cfg_devw),
      .nops  (plan_nops),
      .step  (plan_step)
   );

   flyby_addr_gen #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (ld_addr),
      .adv      (op_now),
      .step     (step_q),
      .addr     (mem_addr)
   );

   flyby_xfer_ctr #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (ld_count),
      .dec      (op_last),
      .zero     (cnt_zero),
      .last     (cnt_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         dir_q  <= 1'b0;
         step_q <= 2'd1;
      end else begin
         unique case (st_q)
            ST_IDLE: if (accept) begin
               st_q   <= ST_OP;
               left_q <= plan_nops - OPW'(1);
               dir_q  <= cfg_dir;
               step_q <= plan_step;
            end
            ST_OP: begin
               if (left_q == '0) begin
                  st_q <= ST_IDLE;
               end else begin
                  st_q   <= ST_GAP;
                  left_q <= left_q - OPW'(1);
               end
            end
            ST_GAP:  st_q <= ST_OP;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         end_q <= op_last && cnt_last;
         if (op_last && cnt_last)
            irq_q <= 1'b1;
         else if (irq_clr)
            irq_q <= 1'b0;
      end
   end

   assign dack_n = !op_now;
   assign mem_rd = op_now && !dir_q;
   assign mem_wr = op_now && dir_q;
   assign end_n  = !end_q;
   assign irq    = irq_q;

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |-> (mem_rd ^ mem_wr));

   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dack_n |=> dack_n);

   assert_end_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !end_n |-> irq);

   assert_end_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !end_n |=> end_n);

   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && (!ch_en || cnt_zero)) |=> dack_n);

endmodule

// File: tb/test_flyby_dma_chan.sv
module test_flyby_dma_chan;

   localparam int AW = 32;
   localparam int CW = 16;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          wr;
      logic          endf;
   } op_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ch_en = 1'b0;
   logic          cfg_dir = 1'b0;
   logic [1:0]    cfg_dsize = 2'b00;
   logic          cfg_devw = 1'b0;
   logic          ld_valid = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [CW-1:0] ld_count = '0;
   logic          irq_clr = 1'b0;
   logic          dreq = 1'b0;
   logic          dack_n, end_n, irq, mem_rd, mem_wr;
   logic [AW-1:0] mem_addr;

   int n_chk = 0;
   int n_bad = 0;
   int ack_seen = 0;
   op_t exp_q[$];
   op_t cur;
   logic pend_end = 1'b0;
   logic prev_ack = 1'b0;
   logic [AW-1:0] addr_m = '0;
   int cnt_m = 0;

   always #4 clk = ~clk;

   flyby_dma_chan #(.AW(AW), .CW(CW)) i_flyby_dma_chan (
      .clk, .rst_n, .ch_en, .cfg_dir, .cfg_dsize, .cfg_devw,
      .ld_valid, .ld_addr, .ld_count, .irq_clr, .dreq,
      .dack_n, .end_n, .irq, .mem_addr, .mem_rd, .mem_wr
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected bus operation per acknowledge pulse.
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ack)
            chk(dack_n == 1'b1, "R6 ack high after op", dack_n, 1);
         if (pend_end || !end_n) begin
            chk(end_n == !pend_end, "R7 end pulse", end_n, !pend_end);
            if (pend_end) chk(irq == 1'b1, "R7 irq with end", irq, 1);
         end
         pend_end = 1'b0;
         if (!dack_n) begin
            ack_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected ack", 0, 1);
            end else begin
               cur = exp_q.pop_front();
               chk(mem_addr == cur.addr, "R2/R5 address", mem_addr, cur.addr);
               chk(mem_wr == cur.wr && mem_rd == !cur.wr, "R3 strobe",
                   {mem_wr, mem_rd}, {cur.wr, !cur.wr});
               pend_end = cur.endf;
            end
         end
         prev_ack = !dack_n;
      end
   end

   function automatic int ops_of(input logic [1:0] ds, input logic dw);
      if (ds == 2'b10) return dw ? 2 : 4;
      if (ds == 2'b01 && !dw) return 2;
      return 1;
   endfunction

   task automatic load(input logic [AW-1:0] a, input int c);
      ld_valid = 1'b1; ld_addr = a; ld_count = CW'(c);
      @(negedge clk);
      ld_valid = 1'b0;
      addr_m = a; cnt_m = c;
   endtask

   // Driver: pushes the expected operations, then raises one request.
   task automatic xfer(input logic dir, input logic [1:0] ds, input logic dw, input string tag);
      int n = ops_of(ds, dw);
      int exp_n = 0;
      int base;
      cfg_dir = dir; cfg_dsize = ds; cfg_devw = dw;
      if (ch_en && cnt_m != 0) begin
         exp_n = n;
         for (int i = 0; i < n; i++) begin
            exp_q.push_back('{addr: addr_m, wr: dir, endf: (i == n-1) && (cnt_m == 1)});
            addr_m = addr_m + (dw ? 2 : 1);
         end
         cnt_m--;
      end
      base = ack_seen;
      dreq = 1'b1;
      @(negedge clk);
      dreq = 1'b0;
      repeat (2*n + 2) @(negedge clk);
      chk(ack_seen - base == exp_n, tag, ack_seen - base, exp_n);
      chk(exp_q.size() == 0, {tag, " queue drained"}, exp_q.size(), 0);
   endtask

   initial begin
      #(8*100000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dack_n == 1 && end_n == 1, "R1 reset strobes", {dack_n, end_n}, 2'b11);
      chk(irq == 0 && mem_rd == 0 && mem_wr == 0, "R1 reset irq/mem", {irq, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      load(32'h1000, 3);
      xfer(1'b0, 2'b10, 1'b0, "R9 disabled request ignored");
      ch_en = 1'b1;
      xfer(1'b0, 2'b10, 1'b0, "R4 32-bit on 8-bit device ops");
      xfer(1'b1, 2'b01, 1'b0, "R4 16-bit on 8-bit device ops");
      xfer(1'b0, 2'b10, 1'b1, "R4 32-bit on 16-bit device ops");
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R8 irq held", irq, 1);
      xfer(1'b1, 2'b00, 1'b0, "R9 zero counter request ignored");
      chk(irq == 1'b1, "R8 irq held after ignored request", irq, 1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq == 1'b0, "R8 irq cleared", irq, 0);
      load(32'h2000, 3);
      xfer(1'b1, 2'b00, 1'b1, "R4 8-bit on 16-bit device ops");
      xfer(1'b0, 2'b01, 1'b1, "R4 16-bit on 16-bit device ops");
      chk(irq == 1'b0, "R7 no irq before counter empties", irq, 0);
      xfer(1'b1, 2'b11, 1'b0, "R4 reserved size code ops");
      chk(irq == 1'b1, "R7 irq after last transfer", irq, 1);
      chk(mem_addr == addr_m, "R5 address after transfers", mem_addr, addr_m);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule